// File: doc/BRIEF.md
# I2C Master Command FIFO Front End

This block sits between the software-visible side of an I2C master and its bit-level bus engine. Software pushes 11-bit command words into a command FIFO. Each word carries a data byte and three control flags: read, stop-after and restart-before. The head of that FIFO is decoded and offered to the bus engine one command at a time through a valid/ready handshake. Bytes that the engine reads off the bus are returned into a receive FIFO, and software pops them through a read strobe.

Both FIFOs report their occupancy. Two programmable thresholds turn the occupancy into status bits. The command-side status means "running low, refill me". The receive-side status means "enough bytes waiting". Misuse is reported by one-cycle pulses: a command written into a full FIFO, a byte arriving from the engine into a full receive FIFO, and a software read of an empty receive FIFO. An abort input empties both FIFOs in a single clock.

Top module: `i2c_cmd_front`

## Requirements
- R1: A command word is decoded as data byte in bits 7:0, read flag in bit 8, stop-after flag in bit 9 and restart-before flag in bit 10. Accepted words reach the engine in the order they were written, with the flags unchanged.
- R2: While the offered command has its read flag set, `eng_cmd_data` is 0 whatever data bits were written.
- R3: `eng_cmd_valid` is high exactly when the command FIFO holds at least one word. The head word is removed at a clock edge where both `eng_cmd_valid` and `eng_cmd_ready` are high.
- R4: `tx_level` and `rx_level` give the number of stored entries. They change one clock after the push or pop that causes the change and never exceed the FIFO depth.
- R5: `tx_low` is high when `tx_level` is less than or equal to `tx_thresh`.
- R6: `rx_ready` is high when `rx_level` is strictly greater than `rx_thresh`, so a threshold of 0 flags a single stored byte.
- R7: `rd_data` shows the oldest stored received byte in bits 7:0. A clock edge with `rd_req` high removes it.
- R8: A command write is accepted only if the command FIFO was not full before that edge, even if the engine pops in the same cycle. A rejected write leaves the contents unchanged and raises `tx_overflow` for the following cycle.
- R9: When the receive FIFO is empty, `rd_data` is 0. A `rd_req` in that state removes nothing and raises `rx_underflow` for the following cycle.
- R10: A byte offered on `eng_rx_valid` while the receive FIFO was full is dropped and raises `rx_overflow` for the following cycle. Bytes already stored are kept.
- R11: A clock edge with `abort` high empties both FIFOs. Every write, read, pop and return in that cycle is ignored, and no error pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_cmd_valid | input | 1 | Software command write strobe |
| wr_cmd_word | input | 11 | Command word (restart, stop, read, data) |
| rd_req | input | 1 | Software receive-byte read strobe |
| rd_data | output | 8 | Oldest received byte, 0 when empty |
| tx_thresh | input | TX_CNT_W | Command-side low threshold |
| rx_thresh | input | RX_CNT_W | Receive-side ready threshold |
| tx_level | output | TX_CNT_W | Command FIFO occupancy |
| rx_level | output | RX_CNT_W | Receive FIFO occupancy |
| tx_low | output | 1 | Command level at or below threshold |
| rx_ready | output | 1 | Receive level above threshold |
| tx_overflow | output | 1 | Pulse: command write dropped |
| rx_overflow | output | 1 | Pulse: returned byte dropped |
| rx_underflow | output | 1 | Pulse: read of empty receive FIFO |
| abort | input | 1 | Flush both FIFOs |
| eng_cmd_valid | output | 1 | A decoded command is offered |
| eng_cmd_ready | input | 1 | Engine takes the offered command |
| eng_cmd_read | output | 1 | Offered command is a read |
| eng_cmd_stop | output | 1 | Stop after this byte |
| eng_cmd_restart | output | 1 | Restart before this byte |
| eng_cmd_data | output | 8 | Write data, 0 for reads |
| eng_rx_valid | input | 1 | Engine returns a read byte |
| eng_rx_byte | input | 8 | Returned byte |

## Verification
Directed phases come first. One writes a short mix of write, read, stop and restart words and holds the engine stalled, which separates threshold status from FIFO ordering. One drains the FIFO with the engine ready, which shows flag decoding and the masking of read data. Others fill each FIFO past its depth, including a simultaneous pop on a full FIFO, which distinguishes a pre-edge admission rule from a post-pop one. Further phases read an empty receive FIFO and abort while every other input is active. A long random phase then moves both thresholds, so that pointer wrap and level accounting are exercised against a queue model on every clock.

// File: rtl/i2cf_pkg.sv
package i2cf_pkg;

    localparam int CMD_W = 11;

    // Bit positions are part of the software-visible command format.
    typedef struct packed {
        logic       restart;  // bit 10
        logic       stop;     // bit 9
        logic       read;     // bit 8
        logic [7:0] data;     // bits 7:0
    } cmd_word_t;

endpackage

// File: rtl/i2cf_fifo.sv
module i2cf_fifo #(
    parameter  int W      = 8,
    parameter  int DEPTH  = 8,
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             drop
);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] count;
        logic             drop;
    } state_t;

    state_t     st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic       do_push;
    logic       do_pop;
    logic       is_full;

    assign is_full = (st_q.count == CNT_W'(DEPTH));
    assign do_push = push && !flush && !is_full;
    assign do_pop  = pop && !flush && (st_q.count != '0);

    always_comb begin
        st_d      = st_q;
        st_d.drop = push && !flush && is_full;
        if (flush) begin
            st_d.wptr  = '0;
            st_d.rptr  = '0;
            st_d.count = '0;
        end else begin
            if (do_push) begin
                st_d.wptr = (st_q.wptr == PTR_W'(DEPTH - 1)) ? '0 : st_q.wptr + 1'b1;
            end
            if (do_pop) begin
                st_d.rptr = (st_q.rptr == PTR_W'(DEPTH - 1)) ? '0 : st_q.rptr + 1'b1;
            end
            st_d.count = st_q.count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[st_q.wptr] <= push_data;
        end
    end

    assign head  = mem[st_q.rptr];
    assign count = st_q.count;
    assign empty = (st_q.count == '0);
    assign drop  = st_q.drop;

endmodule

// File: rtl/i2cf_decode.sv
module i2cf_decode
    import i2cf_pkg::*;
(
    input  cmd_word_t  word,
    input  logic       present,
    output logic       valid,
    output logic       read,
    output logic       stop,
    output logic       restart,
    output logic [7:0] data
);

    always_comb begin
        valid   = present;
        read    = present && word.read;
        stop    = present && word.stop;
        restart = present && word.restart;
        // Data bits of a read command carry no meaning on the bus.
        data    = (present && !word.read) ? word.data : 8'h00;
    end

endmodule

// File: rtl/i2cf_status.sv
module i2cf_status #(
    parameter int TX_CNT_W = 4,
    parameter int RX_CNT_W = 4
) (
    input  logic [TX_CNT_W-1:0] tx_level,
    input  logic [TX_CNT_W-1:0] tx_thresh,
    input  logic [RX_CNT_W-1:0] rx_level,
    input  logic [RX_CNT_W-1:0] rx_thresh,
    output logic                tx_low,
    output logic                rx_ready
);

    always_comb begin
        tx_low   = (tx_level <= tx_thresh);
        rx_ready = (rx_level > rx_thresh);
    end

endmodule

// File: rtl/i2c_cmd_front.sv
module i2c_cmd_front
    import i2cf_pkg::*;
#(
    parameter  int TX_DEPTH = 8,
    parameter  int RX_DEPTH = 8,
    localparam int TX_CNT_W = $clog2(TX_DEPTH + 1),
    localparam int RX_CNT_W = $clog2(RX_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_cmd_valid,
    input  logic [CMD_W-1:0]    wr_cmd_word,
    input  logic                rd_req,
    output logic [7:0]          rd_data,
    input  logic [TX_CNT_W-1:0] tx_thresh,
    input  logic [RX_CNT_W-1:0] rx_thresh,
    output logic [TX_CNT_W-1:0] tx_level,
    output logic [RX_CNT_W-1:0] rx_level,
    output logic                tx_low,
    output logic                rx_ready,
    output logic                tx_overflow,
    output logic                rx_overflow,
    output logic                rx_underflow,
    input  logic                abort,
    output logic                eng_cmd_valid,
    input  logic                eng_cmd_ready,
    output logic                eng_cmd_read,
    output logic                eng_cmd_stop,
    output logic                eng_cmd_restart,
    output logic [7:0]          eng_cmd_data,
    input  logic                eng_rx_valid,
    input  logic [7:0]          eng_rx_byte
);

    typedef struct packed {
        logic under;
    } front_state_t;

    front_state_t fs_d, fs_q;

    logic [CMD_W-1:0] tx_head;
    logic             tx_empty;
    logic [7:0]       rx_head;
    logic             rx_empty;

    i2cf_fifo #(.W(CMD_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (abort),
        .push      (wr_cmd_valid),
        .push_data (wr_cmd_word),
        .pop       (eng_cmd_ready),
        .head      (tx_head),
        .count     (tx_level),
        .empty     (tx_empty),
        .drop      (tx_overflow)
    );

    i2cf_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (abort),
        .push      (eng_rx_valid),
        .push_data (eng_rx_byte),
        .pop       (rd_req),
        .head      (rx_head),
        .count     (rx_level),
        .empty     (rx_empty),
        .drop      (rx_overflow)
    );

    i2cf_decode u_dec (
        .word    (cmd_word_t'(tx_head)),
        .present (!tx_empty),
        .valid   (eng_cmd_valid),
        .read    (eng_cmd_read),
        .stop    (eng_cmd_stop),
        .restart (eng_cmd_restart),
        .data    (eng_cmd_data)
    );

    i2cf_status #(.TX_CNT_W(TX_CNT_W), .RX_CNT_W(RX_CNT_W)) u_stat (
        .tx_level  (tx_level),
        .tx_thresh (tx_thresh),
        .rx_level  (rx_level),
        .rx_thresh (rx_thresh),
        .tx_low    (tx_low),
        .rx_ready  (rx_ready)
    );

    always_comb begin
        fs_d       = fs_q;
        fs_d.under = rd_req && rx_empty && !abort;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_q <= '0;
        end else begin
            fs_q <= fs_d;
        end
    end

    assign rd_data      = rx_empty ? 8'h00 : rx_head;
    assign rx_underflow = fs_q.under;

endmodule

// File: rtl/i2c_cmd_front_chk.sv
module i2c_cmd_front_chk #(
    parameter  int TX_DEPTH = 8,
    parameter  int RX_DEPTH = 8,
    localparam int TX_CNT_W = $clog2(TX_DEPTH + 1),
    localparam int RX_CNT_W = $clog2(RX_DEPTH + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                abort,
    input logic [TX_CNT_W-1:0] tx_level,
    input logic [RX_CNT_W-1:0] rx_level,
    input logic                tx_overflow,
    input logic                rx_overflow,
    input logic                rx_underflow,
    input logic                eng_cmd_valid
);

    a_r4_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level <= TX_CNT_W'(TX_DEPTH)) && (rx_level <= RX_CNT_W'(RX_DEPTH)));

    a_r3_valid_when_stored: assert property (@(posedge clk) disable iff (!rst_n)
        eng_cmd_valid == (tx_level != '0));

    a_r8_tx_ovf_only_full: assert property (@(posedge clk) disable iff (!rst_n)
        tx_overflow |-> $past(tx_level) == TX_CNT_W'(TX_DEPTH));

    a_r10_rx_ovf_only_full: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overflow |-> $past(rx_level) == RX_CNT_W'(RX_DEPTH));

    a_r9_under_only_empty: assert property (@(posedge clk) disable iff (!rst_n)
        rx_underflow |-> $past(rx_level) == '0);

    a_r11_abort_flush: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (tx_level == '0) && (rx_level == '0));

    a_r11_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !tx_overflow && !rx_overflow && !rx_underflow);

endmodule

bind i2c_cmd_front i2c_cmd_front_chk #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .abort         (abort),
    .tx_level      (tx_level),
    .rx_level      (rx_level),
    .tx_overflow   (tx_overflow),
    .rx_overflow   (rx_overflow),
    .rx_underflow  (rx_underflow),
    .eng_cmd_valid (eng_cmd_valid)
);

// File: tb/i2c_cmd_front_test.sv
module i2c_cmd_front_test;

    localparam int D = 8;
    localparam int CW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_cmd_valid = 1'b0;
    logic [10:0] wr_cmd_word = '0;
    logic        rd_req = 1'b0;
    logic [7:0]  rd_data;
    logic [CW-1:0] tx_thresh = '0;
    logic [CW-1:0] rx_thresh = '0;
    logic [CW-1:0] tx_level;
    logic [CW-1:0] rx_level;
    logic        tx_low, rx_ready, tx_overflow, rx_overflow, rx_underflow;
    logic        abort = 1'b0;
    logic        eng_cmd_valid;
    logic        eng_cmd_ready = 1'b0;
    logic        eng_cmd_read, eng_cmd_stop, eng_cmd_restart;
    logic [7:0]  eng_cmd_data;
    logic        eng_rx_valid = 1'b0;
    logic [7:0]  eng_rx_byte = '0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    i2c_cmd_front #(.TX_DEPTH(D), .RX_DEPTH(D)) uut (.*);

    // Behavioural reference model
    logic [10:0] txq[$];
    logic [7:0]  rxq[$];
    logic exp_txovf = 0, exp_rxovf = 0, exp_under = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txq.delete(); rxq.delete();
            exp_txovf <= 0; exp_rxovf <= 0; exp_under <= 0;
        end else if (abort) begin
            txq.delete(); rxq.delete();
            exp_txovf <= 0; exp_rxovf <= 0; exp_under <= 0;
        end else begin
            int tsz, rsz;
            tsz = txq.size();
            rsz = rxq.size();
            exp_txovf <= wr_cmd_valid && (tsz >= D);
            exp_rxovf <= eng_rx_valid && (rsz >= D);
            exp_under <= rd_req && (rsz == 0);
            if (eng_cmd_ready && tsz > 0) void'(txq.pop_front());
            if (wr_cmd_valid && tsz < D) txq.push_back(wr_cmd_word);
            if (rd_req && rsz > 0) void'(rxq.pop_front());
            if (eng_rx_valid && rsz < D) rxq.push_back(eng_rx_byte);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        int ts, rs;
        logic [10:0] h;
        ts = txq.size();
        rs = rxq.size();
        chk(tx_level == CW'(ts), "R4 tx_level", int'(tx_level), ts);
        chk(rx_level == CW'(rs), "R4 rx_level", int'(rx_level), rs);
        chk(tx_low == (ts <= int'(tx_thresh)), "R5 tx_low", int'(tx_low), int'(ts <= int'(tx_thresh)));
        chk(rx_ready == (rs > int'(rx_thresh)), "R6 rx_ready", int'(rx_ready), int'(rs > int'(rx_thresh)));
        chk(eng_cmd_valid == (ts > 0), "R3 eng_cmd_valid", int'(eng_cmd_valid), int'(ts > 0));
        if (ts > 0) begin
            h = txq[0];
            chk({eng_cmd_restart, eng_cmd_stop, eng_cmd_read} == h[10:8], "R1 flags",
                int'({eng_cmd_restart, eng_cmd_stop, eng_cmd_read}), int'(h[10:8]));
            if (h[8]) chk(eng_cmd_data == 8'h00, "R2 read data masked", int'(eng_cmd_data), 0);
            else chk(eng_cmd_data == h[7:0], "R1 write data", int'(eng_cmd_data), int'(h[7:0]));
        end
        if (rs > 0) chk(rd_data == rxq[0], "R7 rd_data", int'(rd_data), int'(rxq[0]));
        else chk(rd_data == 8'h00, "R9 rd_data empty", int'(rd_data), 0);
        chk(tx_overflow == exp_txovf, "R8 tx_overflow", int'(tx_overflow), int'(exp_txovf));
        chk(rx_overflow == exp_rxovf, "R10 rx_overflow", int'(rx_overflow), int'(exp_rxovf));
        chk(rx_underflow == exp_under, "R9 rx_underflow", int'(rx_underflow), int'(exp_under));
    endtask

    // One clock: edge, settle, compare, then the caller drives new inputs.
    task automatic tick();
        @(posedge clk);
        #2;
        compare();
        #1;
    endtask

    task automatic idle();
        wr_cmd_valid = 0; rd_req = 0; eng_cmd_ready = 0; eng_rx_valid = 0; abort = 0;
    endtask

    bit done = 0;
    initial begin
        #(2_000_000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #12;
        // reset state (R4)
        chk(tx_level == 0 && rx_level == 0, "R4 reset levels", int'(tx_level), 0);
        chk(!eng_cmd_valid, "R3 reset valid", int'(eng_cmd_valid), 0);
        rst_n = 1;
        #3;
        tick();

        // Stalled engine: mixed command words, threshold 2 (R1, R2, R5)
        tx_thresh = 2;
        wr_cmd_valid = 1; wr_cmd_word = 11'h0_A5; tick();   // write
        wr_cmd_word = 11'h1_3C; tick();                      // read, data must be masked
        wr_cmd_word = 11'h6_5A; tick();                      // restart+stop write
        wr_cmd_word = 11'h7_FF; tick();                      // read+stop+restart
        idle(); tick();
        chk(tx_low == 1'b0, "R5 tx_low above thresh", int'(tx_low), 0);

        // Drain in order (R1, R3)
        eng_cmd_ready = 1;
        repeat (5) tick();
        idle(); tick();
        chk(!eng_cmd_valid, "R3 drained", int'(eng_cmd_valid), 0);

        // Fill command FIFO past depth (R8)
        wr_cmd_valid = 1;
        for (int i = 0; i < D + 2; i++) begin
            wr_cmd_word = 11'(i);
            tick();
        end
        chk(tx_overflow == 1'b1, "R8 overflow pulse", int'(tx_overflow), 1);
        // Full with simultaneous pop: write still dropped (R8)
        eng_cmd_ready = 1; wr_cmd_word = 11'h0_EE; tick();
        chk(tx_level == CW'(D - 1), "R8 push on full with pop", int'(tx_level), D - 1);
        idle(); tick();

        // Receive path, threshold 0 (R6, R7, R9)
        rx_thresh = 0;
        eng_rx_valid = 1; eng_rx_byte = 8'h11; tick();
        eng_rx_valid = 0;
        chk(rx_ready == 1'b1, "R6 one byte with thresh 0", int'(rx_ready), 1);
        rd_req = 1; tick();
        chk(rd_data == 8'h00, "R9 empty returns zero", int'(rd_data), 0);
        tick();
        chk(rx_underflow == 1'b1, "R9 underflow pulse", int'(rx_underflow), 1);
        rd_req = 0;

        // Overfill receive FIFO (R10)
        eng_rx_valid = 1;
        for (int i = 0; i < D + 1; i++) begin
            eng_rx_byte = 8'(8'h40 + i);
            tick();
        end
        eng_rx_valid = 0; tick();
        chk(rd_data == 8'h40, "R10 stored bytes kept", int'(rd_data), 'h40);

        // Abort with every other input active (R11)
        wr_cmd_valid = 1; wr_cmd_word = 11'h0_33; tick();
        abort = 1; wr_cmd_valid = 1; rd_req = 1; eng_rx_valid = 1; eng_cmd_ready = 1;
        tick();
        idle();
        chk(tx_level == 0 && rx_level == 0, "R11 abort flush", int'({tx_level, rx_level}), 0);
        tick();
        chk(!tx_overflow && !rx_overflow && !rx_underflow, "R11 no pulses", 0, 0);

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            wr_cmd_valid = ($urandom % 3) != 0;
            wr_cmd_word  = 11'($urandom);
            eng_cmd_ready = ($urandom % 3) == 0;
            eng_rx_valid = ($urandom % 2) != 0;
            eng_rx_byte  = 8'($urandom);
            rd_req       = ($urandom % 3) == 0;
            abort        = ($urandom % 97) == 0;
            if (($urandom % 50) == 0) tx_thresh = CW'($urandom % (D + 1));
            if (($urandom % 50) == 0) rx_thresh = CW'($urandom % (D + 1));
            tick();
        end
        idle(); tick();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule